// File: doc/BRIEF.md
# One-Time-Programmable Trim Register Bank

This block holds the calibration trim of a linear magnetic sensor: a coarse range and a fine value for the quiescent output level, a coarse range and a fine value for gain, a temperature-drift code, an output clamp choice, an output polarity bit and a device lock. Every stored bit is the OR of a volatile trial latch and a modelled fuse. Trial latches can be loaded and cleared as often as needed, so an operator can search for a good setting. Blowing a fuse makes a bit permanently 1.

Requests arrive on one valid/ready channel that carries an opcode, a register number and a value. The bank applies back-pressure only while the power-on-reset input is high, because the trial latches are being wiped then. A blow request sets at most one new fuse. It finishes with a one-cycle done pulse, or with an error pulse when it is refused. The outputs carry the effective, decoded settings. Unused codes are folded onto the codes whose effect they share. The fuse flops are cleared only by `rst_n`, which stands for a blank die. The `por_i` input models a supply cycle: the trial latches are cleared and the fuses are kept.

Top module: `otp_trim_bank`

## Requirements
- R1: `req_ready_o` is 0 while `por_i` is 1 and 1 otherwise. A request is taken when `req_valid_i` and `req_ready_o` are both 1. Opcodes: 0 clears, 1 loads a trial value, 2 blows a fuse, 3 does nothing. Register numbers: 0 level coarse (2 bits), 1 level fine (9), 2 gain coarse (2), 3 gain fine (8), 4 drift code (5), 5 clamp (2), 6 polarity (1), 7 lock (1, fuse only). The result shows on the outputs in the cycle after the request is taken.
- R2: Each effective bit is its trial bit OR its fuse bit. A load writes the low bits of `req_val_i` into the trial latches of the selected register. Value bits above the register's width are ignored.
- R3: A clear zeroes the trial latches of the selected register only. Bits whose fuse is blown keep reading 1, and other registers do not change.
- R4: A blow computes the bits that need a new fuse: the value AND NOT the current fuses. If this set has at most one bit, the fuse is set and `blow_done_o` pulses for one cycle. If it has more than one bit, nothing changes and `blow_err_o` pulses. The two pulses never occur together.
- R5: A blown bit never returns to 0. Later blows in the same register add bits, so the fused value is the OR of every blow.
- R6: While `por_i` is 1, all trial latches are cleared and the fuses keep their state. `rst_n` low clears both.
- R7: A blow of register 7 with bit 0 set locks the device. From then on, every request leaves all settings unchanged, and every blow returns an error pulse. The lock survives `por_i`.
- R8: Drift codes 12 to 15 are output as 4 to 7, and codes 28 to 31 are output as 20 to 23. All other codes pass through unchanged.
- R9: Range outputs use 0 for low, 1 for mid and 2 for high. Level coarse code 0 gives mid, 1 gives low, 2 gives high and 3 gives mid. Gain coarse code 0 gives low, 1 gives mid, 2 gives high and 3 gives high.
- R10: Clamp code 0 and code 3 give no clamp (`clamp_en_o`=0). Code 1 gives the narrow margin (`clamp_en_o`=1, `clamp_wide_o`=0). Code 2 gives the wide margin (both 1).
- R11: `polarity_o` equals the effective polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears trial latches and fuses (blank die) |
| por_i | input | 1 | Power-cycle model; clears trial latches only |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready; low during `por_i` |
| req_op_i | input | 2 | Opcode: 0 clear, 1 load, 2 blow, 3 none |
| req_sel_i | input | 3 | Register number |
| req_val_i | input | 9 | Value for load or blow |
| blow_done_o | output | 1 | One-cycle pulse: blow accepted |
| blow_err_o | output | 1 | One-cycle pulse: blow refused |
| qvo_range_o | output | 2 | Decoded level range |
| qvo_fine_o | output | 9 | Effective level fine value |
| sens_range_o | output | 2 | Decoded gain range |
| sens_fine_o | output | 8 | Effective gain fine value |
| tc_code_o | output | 5 | Drift code after aliasing |
| clamp_en_o | output | 1 | Output clamp enabled |
| clamp_wide_o | output | 1 | Wide clamp margin selected |
| polarity_o | output | 1 | Output polarity inverted |
| locked_o | output | 1 | Device lock fuse blown |

## Verification
Every request changes a register on the clock edge that takes it, so both the settings and the done or error pulse are due one cycle later. The decoding between the registers and the outputs is combinational. The bench drives each request on a falling edge, lets one rising edge take it, and reads the outputs and the pulse at the next falling edge. That is the only cycle in which a pulse is high. For the power-cycle case, `por_i` is held for one edge, and the settings are read after that edge, with loads issued before it as the reference.

// File: rtl/otp_trim_pkg.sv
package otp_trim_pkg;
  localparam int NREG  = 8;
  localparam int VW    = 9;
  localparam int SELW  = $clog2(NREG);
  localparam int CNTW  = $clog2(VW + 1);

  localparam int R_QC = 0;
  localparam int R_QF = 1;
  localparam int R_SC = 2;
  localparam int R_SF = 3;
  localparam int R_TC = 4;
  localparam int R_CL = 5;
  localparam int R_PO = 6;
  localparam int R_LK = 7;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_BLOW  = 2'd2,
    OP_NONE  = 2'd3
  } trim_op_e;

  typedef enum logic [1:0] {
    RNG_LOW  = 2'd0,
    RNG_MID  = 2'd1,
    RNG_HIGH = 2'd2
  } range_e;

  function automatic int field_width(int idx);
    case (idx)
      R_QC: return 2;
      R_QF: return 9;
      R_SC: return 2;
      R_SF: return 8;
      R_TC: return 5;
      R_CL: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int field_off(int idx);
    int s;
    s = 0;
    for (int i = 0; i < idx; i++) s += field_width(i);
    return s;
  endfunction

  localparam int TOTW = field_off(NREG);
endpackage

// File: rtl/otp_trim_field.sv
module otp_trim_field #(
  parameter int W        = 2,
  parameter bit VOLATILE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         por_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         blow_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] blow_mask_i,
  output logic [W-1:0] fuse_o,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] trial_q;
  logic [W-1:0] fuse_q;

  generate
    if (VOLATILE) begin : g_trial
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      trial_q <= '0;
        else if (por_i)  trial_q <= '0;
        else if (clr_i)  trial_q <= '0;
        else if (load_i) trial_q <= load_val_i;
      end
    end else begin : g_no_trial
      logic unused_trial;
      assign unused_trial = clr_i ^ load_i ^ (^load_val_i);
      assign trial_q = '0;
    end
  endgenerate

  // fuse model: only a blank-die reset returns bits to 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fuse_q <= '0;
    else if (blow_i) fuse_q <= fuse_q | blow_mask_i;
  end

  assign fuse_o = fuse_q;
  assign eff_o  = trial_q | fuse_q;
endmodule

// File: rtl/otp_trim_decode.sv
module otp_trim_decode
  import otp_trim_pkg::*;
(
  input  logic [TOTW-1:0] eff_i,
  output logic [1:0]      qvo_range_o,
  output logic [8:0]      qvo_fine_o,
  output logic [1:0]      sens_range_o,
  output logic [7:0]      sens_fine_o,
  output logic [4:0]      tc_code_o,
  output logic            clamp_en_o,
  output logic            clamp_wide_o,
  output logic            polarity_o,
  output logic            locked_o
);
  localparam int O_QC = field_off(R_QC);
  localparam int O_QF = field_off(R_QF);
  localparam int O_SC = field_off(R_SC);
  localparam int O_SF = field_off(R_SF);
  localparam int O_TC = field_off(R_TC);
  localparam int O_CL = field_off(R_CL);
  localparam int O_PO = field_off(R_PO);
  localparam int O_LK = field_off(R_LK);

  logic [1:0] qc, sc, cl;
  logic [4:0] tc;

  assign qc = eff_i[O_QC +: 2];
  assign sc = eff_i[O_SC +: 2];
  assign cl = eff_i[O_CL +: 2];
  assign tc = eff_i[O_TC +: 5];

  always_comb begin
    case (qc)
      2'd1:    qvo_range_o = RNG_LOW;
      2'd2:    qvo_range_o = RNG_HIGH;
      default: qvo_range_o = RNG_MID;
    endcase
    case (sc)
      2'd0:    sens_range_o = RNG_LOW;
      2'd1:    sens_range_o = RNG_MID;
      default: sens_range_o = RNG_HIGH;
    endcase
    // unused drift codes share the effect of the code eight below
    tc_code_o    = (tc[3] & tc[2]) ? {tc[4], 1'b0, tc[2:0]} : tc;
    clamp_en_o   = (cl == 2'd1) || (cl == 2'd2);
    clamp_wide_o = (cl == 2'd2);
  end

  assign qvo_fine_o  = eff_i[O_QF +: 9];
  assign sens_fine_o = eff_i[O_SF +: 8];
  assign polarity_o  = eff_i[O_PO];
  assign locked_o    = eff_i[O_LK];
endmodule

// File: rtl/otp_trim_bank.sv
module otp_trim_bank
  import otp_trim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [1:0]  req_op_i,
  input  logic [2:0]  req_sel_i,
  input  logic [8:0]  req_val_i,
  output logic        blow_done_o,
  output logic        blow_err_o,
  output logic [1:0]  qvo_range_o,
  output logic [8:0]  qvo_fine_o,
  output logic [1:0]  sens_range_o,
  output logic [7:0]  sens_fine_o,
  output logic [4:0]  tc_code_o,
  output logic        clamp_en_o,
  output logic        clamp_wide_o,
  output logic        polarity_o,
  output logic        locked_o
);
  logic [TOTW-1:0]            eff_flat;
  logic [NREG-1:0][CNTW-1:0]  new_cnt;
  logic                       take, active, blow_ok, blow_bad;
  logic [CNTW-1:0]            sel_cnt;
  logic                       done_q, err_q;
  trim_op_e                   op;

  assign op          = trim_op_e'(req_op_i);
  assign req_ready_o = ~por_i;
  assign take        = req_valid_i & req_ready_o;
  assign active      = take & ~locked_o;
  assign sel_cnt     = new_cnt[req_sel_i];
  assign blow_ok     = active && (op == OP_BLOW) && (sel_cnt <= CNTW'(1));
  assign blow_bad    = take && (op == OP_BLOW) && (locked_o || (sel_cnt > CNTW'(1)));

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam int W = field_width(g);
      logic         hit;
      logic [W-1:0] fuse_w, eff_w, need_w;

      assign hit       = (req_sel_i == SELW'(g));
      assign need_w    = req_val_i[W-1:0] & ~fuse_w;
      assign new_cnt[g] = CNTW'($countones(need_w));

      otp_trim_field #(.W(W), .VOLATILE(g != R_LK)) u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_i      (por_i),
        .clr_i      (active && op == OP_CLEAR && hit),
        .load_i     (active && op == OP_LOAD && hit),
        .blow_i     (blow_ok && hit),
        .load_val_i (req_val_i[W-1:0]),
        .blow_mask_i(need_w),
        .fuse_o     (fuse_w),
        .eff_o      (eff_w)
      );

      assign eff_flat[field_off(g) +: W] = eff_w;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= blow_ok;
      err_q  <= blow_bad;
    end
  end

  assign blow_done_o = done_q;
  assign blow_err_o  = err_q;

  otp_trim_decode u_dec (
    .eff_i       (eff_flat),
    .qvo_range_o (qvo_range_o),
    .qvo_fine_o  (qvo_fine_o),
    .sens_range_o(sens_range_o),
    .sens_fine_o (sens_fine_o),
    .tc_code_o   (tc_code_o),
    .clamp_en_o  (clamp_en_o),
    .clamp_wide_o(clamp_wide_o),
    .polarity_o  (polarity_o),
    .locked_o    (locked_o)
  );
endmodule

// File: rtl/otp_trim_checker.sv
module otp_trim_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       por_i,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [1:0] req_op_i,
  input logic       blow_done_o,
  input logic       blow_err_o,
  input logic [8:0] qvo_fine_o,
  input logic [7:0] sens_fine_o,
  input logic [4:0] tc_code_o,
  input logic       locked_o
);
  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(blow_done_o && blow_err_o));

  p_done_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && req_op_i == 2'd2) |=> !(blow_done_o && blow_err_o));

  p_done_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_i && req_ready_o && req_op_i == 2'd2) |=> !blow_done_o && !blow_err_o);

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o);

  p_lock_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !por_i) |=> $stable(qvo_fine_o) && $stable(sens_fine_o) && $stable(tc_code_o));

  p_lock_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && req_valid_i && req_ready_o && req_op_i == 2'd2) |=> blow_err_o);

  p_tc_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc_code_o[3:2] != 2'b11);
endmodule

bind otp_trim_bank otp_trim_checker u_otp_trim_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_i      (por_i),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_op_i   (req_op_i),
  .blow_done_o(blow_done_o),
  .blow_err_o (blow_err_o),
  .qvo_fine_o (qvo_fine_o),
  .sens_fine_o(sens_fine_o),
  .tc_code_o  (tc_code_o),
  .locked_o   (locked_o)
);

// File: tb/otp_trim_bank_bench.sv
module otp_trim_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_i = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [1:0] req_op_i = 2'd3;
  logic [2:0] req_sel_i = 3'd0;
  logic [8:0] req_val_i = 9'd0;
  logic       blow_done_o, blow_err_o;
  logic [1:0] qvo_range_o, sens_range_o;
  logic [8:0] qvo_fine_o;
  logic [7:0] sens_fine_o;
  logic [4:0] tc_code_o;
  logic       clamp_en_o, clamp_wide_o, polarity_o, locked_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  otp_trim_bank u_otp_trim_bank (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive on a falling edge, one rising edge takes it, read at next falling edge
  task automatic req(input logic [1:0] op, input logic [2:0] sel, input logic [8:0] val);
    req_op_i = op; req_sel_i = sel; req_val_i = val; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0; req_op_i = 2'd3;
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", req_ready_o, 1);
    chk("R9 level range at blank", qvo_range_o, 1);
    chk("R9 gain range at blank", sens_range_o, 0);
    chk("R2 level fine at blank", qvo_fine_o, 0);
    chk("R10 clamp at blank", clamp_en_o, 0);
    chk("R7 unlocked at blank", locked_o, 0);
  endtask

  task automatic t_load_clear;
    req(2'd1, 3'd1, 9'h1A5);
    chk("R2 load level fine", qvo_fine_o, 'h1A5);
    req(2'd1, 3'd3, 9'h13C);
    chk("R2 upper bits ignored", sens_fine_o, 'h3C);
    req(2'd0, 3'd1, 9'h0);
    chk("R3 clear level fine", qvo_fine_o, 0);
    chk("R3 other register kept", sens_fine_o, 'h3C);
    req(2'd3, 3'd3, 9'h0);
    chk("R1 opcode 3 no effect", sens_fine_o, 'h3C);
  endtask

  task automatic t_blow;
    req(2'd2, 3'd1, 9'h010);
    chk("R4 single blow done", blow_done_o, 1);
    chk("R4 single blow no err", blow_err_o, 0);
    chk("R4 fused bit visible", qvo_fine_o, 'h010);
    @(negedge clk);
    chk("R4 done is one cycle", blow_done_o, 0);
    req(2'd1, 3'd1, 9'h003);
    chk("R2 trial OR fuse", qvo_fine_o, 'h013);
    req(2'd0, 3'd1, 9'h0);
    chk("R3 clear keeps blown bit", qvo_fine_o, 'h010);
    req(2'd2, 3'd1, 9'h011);
    chk("R5 one new bit accepted", blow_done_o, 1);
    chk("R5 fuses accumulate", qvo_fine_o, 'h011);
    req(2'd2, 3'd1, 9'h006);
    chk("R4 two new bits rejected", blow_err_o, 1);
    chk("R4 reject no done", blow_done_o, 0);
    chk("R4 reject no change", qvo_fine_o, 'h011);
  endtask

  task automatic t_por;
    por_i = 1'b1;
    #1;
    chk("R1 ready low in por", req_ready_o, 0);
    @(negedge clk);
    por_i = 1'b0;
    chk("R6 trial cleared", sens_fine_o, 0);
    chk("R6 fuses kept", qvo_fine_o, 'h011);
    chk("R5 fuse never reverts", qvo_fine_o & 'h011, 'h011);
  endtask

  task automatic t_decode;
    req(2'd1, 3'd4, 9'd13);  chk("R8 code 13 -> 5", tc_code_o, 5);
    req(2'd1, 3'd4, 9'd29);  chk("R8 code 29 -> 21", tc_code_o, 21);
    req(2'd1, 3'd4, 9'd11);  chk("R8 code 11 kept", tc_code_o, 11);
    req(2'd1, 3'd4, 9'd20);  chk("R8 code 20 kept", tc_code_o, 20);
    req(2'd1, 3'd0, 9'd1);   chk("R9 level code1 low", qvo_range_o, 0);
    req(2'd1, 3'd0, 9'd2);   chk("R9 level code2 high", qvo_range_o, 2);
    req(2'd1, 3'd0, 9'd3);   chk("R9 level code3 mid", qvo_range_o, 1);
    req(2'd1, 3'd2, 9'd1);   chk("R9 gain code1 mid", sens_range_o, 1);
    req(2'd1, 3'd2, 9'd3);   chk("R9 gain code3 high", sens_range_o, 2);
    req(2'd1, 3'd5, 9'd1);
    chk("R10 clamp narrow en", clamp_en_o, 1);
    chk("R10 clamp narrow", clamp_wide_o, 0);
    req(2'd1, 3'd5, 9'd2);   chk("R10 clamp wide", clamp_wide_o, 1);
    req(2'd1, 3'd5, 9'd3);   chk("R10 clamp code3 off", clamp_en_o, 0);
    req(2'd1, 3'd6, 9'd1);   chk("R11 polarity set", polarity_o, 1);
    req(2'd0, 3'd6, 9'd0);   chk("R11 polarity clear", polarity_o, 0);
  endtask

  task automatic t_lock;
    req(2'd1, 3'd3, 9'h055);
    req(2'd1, 3'd7, 9'h001);
    chk("R7 trial load cannot lock", locked_o, 0);
    req(2'd2, 3'd7, 9'h001);
    chk("R7 lock blow done", blow_done_o, 1);
    chk("R7 locked", locked_o, 1);
    req(2'd1, 3'd3, 9'h0AA);
    chk("R7 load ignored", sens_fine_o, 'h055);
    req(2'd0, 3'd3, 9'h0);
    chk("R7 clear ignored", sens_fine_o, 'h055);
    req(2'd2, 3'd1, 9'h100);
    chk("R7 blow rejected", blow_err_o, 1);
    chk("R7 blow no change", qvo_fine_o, 'h011);
    por_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0;
    chk("R7 lock survives por", locked_o, 1);
    chk("R6 fuses survive por", qvo_fine_o, 'h011);
  endtask

  task automatic t_blank;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R6 rst_n clears fuses", qvo_fine_o, 0);
    chk("R6 rst_n clears lock", locked_o, 0);
  endtask

  initial begin
    #100000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_clear();
    t_blow();
    t_por();
    t_decode();
    t_lock();
    t_blank();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule